// File: doc/BRIEF.md
# Status Register and Block Protection Unit

This unit sits beside the command sequencer of a serial nonvolatile memory. It keeps the write-enable latch, the two protection-level bits and the hardware-lock enable bit, and it builds the 8-bit status byte that a status-read command shifts out. It also tells the sequencer two things. The first is whether a status-register write may be accepted. The second is whether the array address currently under test lies inside the protected zone.

The sequencer sends single-cycle strobes into the unit. These strobes mark the write-enable and write-disable opcodes, the arrival of the data byte of a status write, and the deassertion of chip select. The sequencer also drives the level of the write-protect pin and its own busy flag, which stays high for the whole self-timed program cycle. A status write works in two steps. The data byte is first held as pending while chip select is still low. It is then committed when chip select rises. While it is pending, the hardware lock can cancel it. The nonvolatile bits are modelled as registers that take a parameter value at reset.

Top module: `stat_prot_unit`

## Requirements
- R1: After reset, with the default reset value for the nonvolatile bits, status_o reads 0x00 and sr_wr_ok_o is 0.
- R2: When busy_i is 1, status_o is 0xFF in the same cycle. When busy_i is 0, status_o is {lock enable, 0, 0, 0, level[1], level[0], write-enable latch, 0}, with bit 7 the lock enable.
- R3: addr_prot_o depends only on the current inputs and compares the two most significant address bits with the protection level. Level 00 protects no address. Level 01 protects addresses whose top two bits are 11. Level 10 protects addresses whose top bit is 1. Level 11 protects every address.
- R4: A pulse on wel_set_i sets the write-enable latch, and a pulse on wel_clr_i clears it, one cycle later. The level of wp_pin_i has no effect on either. If both pulses arrive in the same cycle, the clear wins.
- R5: In the cycle after busy_i falls from 1 to 0, the write-enable latch is cleared. This clear wins over a set pulse in that same cycle.
- R6: sr_wr_ok_o is 1 exactly when the latch is set, busy_i is 0, and the hardware lock is off. The hardware lock is on only when wp_pin_i is 0 and the lock enable bit is 1. When the lock enable bit is 0, wp_pin_i has no effect.
- R7: A status write stores the data byte on sr_load_i while sr_wr_ok_o is 1. It commits that byte on the next cs_rise_i. After the commit, data bit 7 becomes the lock enable and data bits 3:2 become the level. The new values show on status_o one cycle later. The other data bits have no effect. The write-enable latch stays set until the program cycle ends.
- R8: A data byte strobed while sr_wr_ok_o is 0 is dropped, and the following cs_rise_i changes nothing.
- R9: If the hardware lock becomes active after the data byte has been received but before cs_rise_i, the pending write is cancelled, and a later cs_rise_i changes nothing.
- R10: While wp_pin_i stays 0 and the lock enable bit is 1, the lock enable bit cannot be cleared. Once wp_pin_i returns to 1, the status register can be written again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wp_pin_i | input | 1 | Write-protect pin level (0 = asserted) |
| wel_set_i | input | 1 | Write-enable opcode strobe |
| wel_clr_i | input | 1 | Write-disable opcode strobe |
| sr_load_i | input | 1 | Status-write data byte received strobe |
| sr_data_i | input | 8 | Status-write data byte |
| cs_rise_i | input | 1 | Chip-select deassertion strobe |
| busy_i | input | 1 | Self-timed program cycle in progress |
| addr_i | input | ADDR_W | Array address under test |
| status_o | output | 8 | Status byte |
| sr_wr_ok_o | output | 1 | Status-register write allowed |
| addr_prot_o | output | 1 | addr_i lies in the protected zone |

## Verification
The outputs fall into two timing groups, and each check waits for the right one:

- **Same cycle.** The status byte while busy, the write-allowed flag and the address-protected flag are combinational. The bench changes the input on a falling edge and samples a few nanoseconds later, in the same cycle.
- **Next cycle.** Changes to the latch and to the nonvolatile bits become visible in the cycle after their strobe. Each strobe is held for exactly one rising edge, and the result is read at the following falling edge.
- **Latch clear at the end of a program cycle.** This is due one edge after busy_i is seen low. The bench reads it one cycle after dropping busy_i.

The WP cancel case holds the pin low for a single edge between the data byte and the chip-select strobe. Only the cancel path can then explain an unchanged status.

// File: rtl/sprot_pkg.sv
package sprot_pkg;

    typedef enum logic [1:0] {
        LVL_NONE    = 2'b00,
        LVL_QUARTER = 2'b01,
        LVL_HALF    = 2'b10,
        LVL_FULL    = 2'b11
    } prot_lvl_e;

    typedef struct packed {
        logic      lock_en;
        prot_lvl_e lvl;
    } nv_bits_t;

    localparam int STAT_W     = 8;
    localparam int POS_LOCK   = 7;
    localparam int POS_LVL_HI = 3;
    localparam int POS_LVL_LO = 2;
    localparam int POS_WEL    = 1;
    localparam int POS_BUSY   = 0;

    // Extract the nonvolatile fields from a written status byte
    function automatic nv_bits_t nv_from_byte(input logic [STAT_W-1:0] b);
        nv_bits_t r;
        r.lock_en = b[POS_LOCK];
        r.lvl     = prot_lvl_e'(b[POS_LVL_HI:POS_LVL_LO]);
        return r;
    endfunction

    // Assemble the status byte seen by a status read
    function automatic logic [STAT_W-1:0] pack_status(input nv_bits_t nv,
                                                      input logic wel,
                                                      input logic busy);
        logic [STAT_W-1:0] s;
        if (busy) begin
            s = '1;
        end else begin
            s                         = '0;
            s[POS_LOCK]               = nv.lock_en;
            s[POS_LVL_HI:POS_LVL_LO]  = nv.lvl;
            s[POS_WEL]                = wel;
            s[POS_BUSY]               = 1'b0;
        end
        return s;
    endfunction

    // Zone membership from the two top address bits
    function automatic logic zone_hit(input prot_lvl_e lvl,
                                      input logic top1,
                                      input logic top2);
        logic h;
        case (lvl)
            LVL_NONE:    h = 1'b0;
            LVL_QUARTER: h = top1 & top2;
            LVL_HALF:    h = top1;
            default:     h = 1'b1;
        endcase
        return h;
    endfunction

endpackage

// File: rtl/sprot_wel.sv
module sprot_wel (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    input  logic busy_i,
    output logic wel_o
);
    logic busy_q;
    logic wel_q;
    logic cycle_end;

    // Program cycle finished: busy seen high last edge, low now
    assign cycle_end = busy_q & ~busy_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            wel_q  <= 1'b0;
        end else begin
            busy_q <= busy_i;
            if (cycle_end || clr_i) begin
                wel_q <= 1'b0;
            end else if (set_i) begin
                wel_q <= 1'b1;
            end
        end
    end

    assign wel_o = wel_q;
endmodule

// File: rtl/sprot_nvreg.sv
module sprot_nvreg
    import sprot_pkg::*;
#(
    parameter logic [STAT_W-1:0] NV_RST = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [STAT_W-1:0] data_i,
    input  logic              commit_i,
    input  logic              allow_i,
    input  logic              lock_i,
    output nv_bits_t          nv_o
);
    nv_bits_t nv_q;
    nv_bits_t shadow_q;
    logic     pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            nv_q     <= nv_from_byte(NV_RST);
            shadow_q <= nv_from_byte('0);
            pend_q   <= 1'b0;
        end else begin
            if (commit_i) begin
                // Chip select released: commit only an uncancelled write
                pend_q <= 1'b0;
                if (pend_q && !lock_i) begin
                    nv_q <= shadow_q;
                end
            end else if (lock_i) begin
                // Hardware lock while select is held drops the pending byte
                pend_q <= 1'b0;
            end else if (load_i && allow_i) begin
                pend_q   <= 1'b1;
                shadow_q <= nv_from_byte(data_i);
            end
        end
    end

    assign nv_o = nv_q;
endmodule

// File: rtl/sprot_zone.sv
module sprot_zone
    import sprot_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  prot_lvl_e         lvl_i,
    output logic              hit_o
);
    logic top1;
    logic top2;
    logic unused_addr;

    generate
        if (ADDR_W >= 2) begin : g_two_msb
            assign top1 = addr_i[ADDR_W-1];
            assign top2 = addr_i[ADDR_W-2];
        end else begin : g_one_msb
            assign top1 = addr_i[0];
            assign top2 = addr_i[0];
        end
    endgenerate

    assign unused_addr = ^addr_i;
    assign hit_o       = zone_hit(lvl_i, top1, top2);
endmodule

// File: rtl/stat_prot_unit.sv
module stat_prot_unit
    import sprot_pkg::*;
#(
    parameter int          ADDR_W = 16,
    parameter logic [7:0]  NV_RST = 8'h00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wp_pin_i,
    input  logic              wel_set_i,
    input  logic              wel_clr_i,
    input  logic              sr_load_i,
    input  logic [7:0]        sr_data_i,
    input  logic              cs_rise_i,
    input  logic              busy_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [7:0]        status_o,
    output logic              sr_wr_ok_o,
    output logic              addr_prot_o
);
    nv_bits_t nv;
    logic     wel;
    logic     hw_lock;

    // Pin only matters once the lock enable bit is set
    assign hw_lock    = ~wp_pin_i & nv.lock_en;
    assign sr_wr_ok_o = wel & ~busy_i & ~hw_lock;

    sprot_wel u_wel (
        .clk    (clk),
        .rst    (rst),
        .set_i  (wel_set_i),
        .clr_i  (wel_clr_i),
        .busy_i (busy_i),
        .wel_o  (wel)
    );

    sprot_nvreg #(
        .NV_RST (NV_RST)
    ) u_nv (
        .clk      (clk),
        .rst      (rst),
        .load_i   (sr_load_i),
        .data_i   (sr_data_i),
        .commit_i (cs_rise_i),
        .allow_i  (sr_wr_ok_o),
        .lock_i   (hw_lock),
        .nv_o     (nv)
    );

    sprot_zone #(
        .ADDR_W (ADDR_W)
    ) u_zone (
        .addr_i (addr_i),
        .lvl_i  (nv.lvl),
        .hit_o  (addr_prot_o)
    );

    assign status_o = pack_status(nv, wel, busy_i);
endmodule

// File: rtl/stat_prot_chk.sv
module stat_prot_chk (
    input logic       clk,
    input logic       rst,
    input logic       wp_pin_i,
    input logic       wel_clr_i,
    input logic       busy_i,
    input logic [7:0] status_o,
    input logic       sr_wr_ok_o,
    input logic       addr_prot_o
);
    a_r2_busy_all_ones: assert property (@(posedge clk) disable iff (rst)
        busy_i |-> status_o == 8'hFF);

    a_r2_idle_spare_zero: assert property (@(posedge clk) disable iff (rst)
        !busy_i |-> (status_o[6:4] == 3'b000 && !status_o[0]));

    a_r3_full_zone: assert property (@(posedge clk) disable iff (rst)
        (!busy_i && status_o[3:2] == 2'b11) |-> addr_prot_o);

    a_r3_empty_zone: assert property (@(posedge clk) disable iff (rst)
        (!busy_i && status_o[3:2] == 2'b00) |-> !addr_prot_o);

    a_r4_clear_latch: assert property (@(posedge clk) disable iff (rst)
        (wel_clr_i && !busy_i) |=> (busy_i || !status_o[1]));

    a_r5_cycle_end_clear: assert property (@(posedge clk) disable iff (rst)
        ($past(busy_i) && !busy_i) |=> (busy_i || !status_o[1]));

    a_r6_ok_needs_latch: assert property (@(posedge clk) disable iff (rst)
        sr_wr_ok_o |-> (!busy_i && status_o[1]));

    a_r6_lock_blocks: assert property (@(posedge clk) disable iff (rst)
        (!wp_pin_i && !busy_i && status_o[7]) |-> !sr_wr_ok_o);

    a_r10_lock_sticky: assert property (@(posedge clk) disable iff (rst)
        (!wp_pin_i && !busy_i && status_o[7]) |=> (wp_pin_i || busy_i || status_o[7]));
endmodule

bind stat_prot_unit stat_prot_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .wp_pin_i    (wp_pin_i),
    .wel_clr_i   (wel_clr_i),
    .busy_i      (busy_i),
    .status_o    (status_o),
    .sr_wr_ok_o  (sr_wr_ok_o),
    .addr_prot_o (addr_prot_o)
);

// File: tb/tb_stat_prot_unit.sv
module tb_stat_prot_unit;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wp_pin_i = 1'b1;
    logic          wel_set_i = 1'b0;
    logic          wel_clr_i = 1'b0;
    logic          sr_load_i = 1'b0;
    logic [7:0]    sr_data_i = 8'h00;
    logic          cs_rise_i = 1'b0;
    logic          busy_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [7:0]    status_o;
    logic          sr_wr_ok_o;
    logic          addr_prot_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    stat_prot_unit #(.ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .wp_pin_i(wp_pin_i),
        .wel_set_i(wel_set_i), .wel_clr_i(wel_clr_i),
        .sr_load_i(sr_load_i), .sr_data_i(sr_data_i),
        .cs_rise_i(cs_rise_i), .busy_i(busy_i), .addr_i(addr_i),
        .status_o(status_o), .sr_wr_ok_o(sr_wr_ok_o), .addr_prot_o(addr_prot_o)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic wel_set;
        @(negedge clk) wel_set_i = 1'b1;
        @(negedge clk) wel_set_i = 1'b0;
        #2;
    endtask

    task automatic wel_clr;
        @(negedge clk) wel_clr_i = 1'b1;
        @(negedge clk) wel_clr_i = 1'b0;
        #2;
    endtask

    task automatic sr_write(input logic [7:0] d);
        @(negedge clk) begin sr_data_i = d; sr_load_i = 1'b1; end
        @(negedge clk) begin sr_load_i = 1'b0; cs_rise_i = 1'b1; end
        @(negedge clk) cs_rise_i = 1'b0;
        #2;
    endtask

    task automatic run_cycle(input int n);
        @(negedge clk) busy_i = 1'b1;
        #2;
        chk("R2 busy status", {8'h0, status_o}, 16'h00FF);
        repeat (n) @(negedge clk);
        busy_i = 1'b0;
        @(negedge clk);
        #2;
    endtask

    task automatic probe(input logic [AW-1:0] a, input logic exp, input string req);
        addr_i = a;
        #1;
        chk(req, {15'h0, addr_prot_o}, {15'h0, exp});
    endtask

    task automatic t_reset;
        chk("R1 reset status", {8'h0, status_o}, 16'h0000);
        chk("R1 reset ok", {15'h0, sr_wr_ok_o}, 16'h0000);
        probe(16'hFFFF, 1'b0, "R3 level 00 top");
    endtask

    task automatic t_latch;
        wel_set;
        chk("R4 set latch", {8'h0, status_o}, 16'h0002);
        chk("R6 ok with latch", {15'h0, sr_wr_ok_o}, 16'h0001);
        wel_clr;
        chk("R4 clear latch", {8'h0, status_o}, 16'h0000);
        wp_pin_i = 1'b0;
        wel_set;
        chk("R4 set with WP low", {8'h0, status_o}, 16'h0002);
        chk("R6 WP ignored when unlocked", {15'h0, sr_wr_ok_o}, 16'h0001);
        wel_clr;
        chk("R4 clear with WP low", {8'h0, status_o}, 16'h0000);
        wp_pin_i = 1'b1;
        @(negedge clk) begin wel_set_i = 1'b1; wel_clr_i = 1'b1; end
        @(negedge clk) begin wel_set_i = 1'b0; wel_clr_i = 1'b0; end
        #2;
        chk("R4 clear beats set", {8'h0, status_o}, 16'h0000);
    endtask

    task automatic t_cycle_end;
        wel_set;
        run_cycle(3);
        chk("R5 latch cleared at cycle end", {8'h0, status_o}, 16'h0000);
        @(negedge clk) busy_i = 1'b1;
        @(negedge clk) begin busy_i = 1'b0; wel_set_i = 1'b1; end
        @(negedge clk) wel_set_i = 1'b0;
        #2;
        chk("R5 cycle end beats set", {8'h0, status_o}, 16'h0000);
    endtask

    task automatic t_levels;
        wel_set;
        sr_write(8'h84);
        chk("R7 commit level 01 lock 1", {8'h0, status_o}, 16'h0086);
        run_cycle(2);
        chk("R7 latch gone after cycle", {8'h0, status_o}, 16'h0084);
        probe(16'hC000, 1'b1, "R3 level 01 C000");
        probe(16'hBFFF, 1'b0, "R3 level 01 BFFF");
        wel_set;
        sr_write(8'h08);
        run_cycle(2);
        chk("R7 level 10 lock 0", {8'h0, status_o}, 16'h0008);
        probe(16'h8000, 1'b1, "R3 level 10 8000");
        probe(16'h7FFF, 1'b0, "R3 level 10 7FFF");
        wel_set;
        sr_write(8'h7D);
        run_cycle(2);
        chk("R7 spare data bits dropped", {8'h0, status_o}, 16'h000C);
        probe(16'h0000, 1'b1, "R3 level 11 0000");
    endtask

    task automatic t_no_latch;
        sr_write(8'h80);
        chk("R8 write without latch dropped", {8'h0, status_o}, 16'h000C);
    endtask

    task automatic t_cancel;
        wel_set;
        sr_write(8'h84);
        run_cycle(2);
        chk("R7 setup lock on", {8'h0, status_o}, 16'h0084);
        wel_set;
        @(negedge clk) begin sr_data_i = 8'h00; sr_load_i = 1'b1; end
        @(negedge clk) begin sr_load_i = 1'b0; wp_pin_i = 1'b0; end
        @(negedge clk) wp_pin_i = 1'b1;
        @(negedge clk) cs_rise_i = 1'b1;
        @(negedge clk) cs_rise_i = 1'b0;
        #2;
        chk("R9 WP pulse cancels pending write", {8'h0, status_o}, 16'h0086);
        wel_clr;
    endtask

    task automatic t_lock;
        wp_pin_i = 1'b0;
        wel_set;
        chk("R6 lock blocks ok", {15'h0, sr_wr_ok_o}, 16'h0000);
        sr_write(8'h00);
        chk("R10 lock enable held", {8'h0, status_o}, 16'h0086);
        wp_pin_i = 1'b1;
        #2;
        chk("R10 ok back after WP high", {15'h0, sr_wr_ok_o}, 16'h0001);
        sr_write(8'h00);
        chk("R10 writable after WP high", {8'h0, status_o}, 16'h0002);
        run_cycle(2);
        chk("R5 latch cleared", {8'h0, status_o}, 16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #2;
        t_reset;
        t_latch;
        t_cycle_end;
        t_levels;
        t_no_latch;
        t_cancel;
        t_lock;
        done = 1'b1;
        report;
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report;
            $finish;
        end
    end
endmodule